// File: doc/BRIEF.md
# Converter Control and Bus-Read Interface

This block is the digital front end of a 12-bit successive-approximation converter that sits on a processor bus. A conversion begins when three control inputs all reach their active levels: chip enable high, active-low chip select low and read/convert low. Whichever of the three arrives last triggers the start. A busy output stays high for the whole conversion. A cycle counter stands in for the approximation sequence, and the result word is captured from a sample input port when the conversion ends.

Once the conversion is done, the result is read over a 12-line data bus. Each line is modelled as a value plus an active-high enable, which stands in for a tri-state pin. A width-mode input chooses the read format. In wide mode the whole word is driven. In byte mode, a byte-select bit picks either the upper eight result bits or a second byte holding the low four result bits. A byte-select change blanks both byte groups for one cycle, so the two groups are never enabled together.

Top module: `adc_bus_ctrl`

## Requirements
- R1: A synchronous active-high reset sets busy low, sets every enable low and clears the result, so the first full-word read after reset returns zero.
- R2: A conversion starts when the condition chipEn=1, chipSelN=0, readConvN=0 goes from false to true while idle. Any of the three inputs may be the last one to change. busy is high after the next clock edge.
- R3: busy stays high for exactly CONV_CYCLES clock cycles (13 by default) and then falls.
- R4: A start condition that arises while busy is high neither restarts nor lengthens the conversion. A condition held true across the end of a conversion does not start another one.
- R5: The result equals the sampleIn value present at the clock edge where busy falls.
- R6: dataOe is all zero unless readConvN=1, busy=0, chipEn=1 and chipSelN=0 all hold at once.
- R7: With wideMode=1 and a read active, dataOe=12'hFFF and dataOut equals the result, whatever byteSel is.
- R8: With wideMode=0, byteSel=0 held steady and a read active, dataOe=12'hFF0 and dataOut[11:4] equals result[11:4].
- R9: With wideMode=0, byteSel=1 held steady and a read active, dataOe=12'h0FF, dataOut[7:4] is zero and dataOut[3:0] equals result[3:0].
- R10: In byte mode, a change of byteSel disables both groups immediately and until the next clock edge. The upper-byte and lower-byte groups are never enabled in the same cycle.
- R11: Every line whose enable is low carries the value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chipEn | input | 1 | Chip enable, active high |
| chipSelN | input | 1 | Chip select, active low |
| readConvN | input | 1 | High selects read, low selects convert |
| wideMode | input | 1 | 1 = full-word read, 0 = byte read |
| byteSel | input | 1 | Byte read: 0 = upper byte, 1 = lower byte |
| sampleIn | input | 12 | Word captured as the conversion result |
| busy | output | 1 | High while a conversion is running |
| dataOut | output | 12 | Data line values |
| dataOe | output | 12 | Per-line output enable, active high |

## Verification
The bench lets each of the three control inputs in turn be the last to arrive. A design that treats one input as the only trigger would never raise busy in some of these runs. It retriggers the start condition in the middle of a conversion and holds it past the end. A level-sensitive or restartable start would show up there as a busy period longer than 13 cycles or as an extra conversion. It also changes sampleIn late in a conversion, which exposes a capture taken on the wrong cycle. A near-exhaustive sweep covers every control, width and byte combination and computes the expected enables and values, and byte-select toggles are sampled inside the blanking cycle. A design without break-before-make would drive a byte group during that cycle, and a wrong byte layout would show up as misplaced enables or non-zero padding.

// File: rtl/adcbus_pkg.sv
package adcbus_pkg;

  // Strobes passed from the control section to the datapath
  typedef struct packed {
    logic loadResult;  // capture sampleIn into the result register
    logic readWide;    // drive the full word
    logic readHigh;    // drive the upper byte group
    logic readLow;     // drive the lower byte group
  } strobe_t;

endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import adcbus_pkg::*;
#(
  parameter int CONV_CYCLES = 13
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    chipEn,
  input  logic    chipSelN,
  input  logic    readConvN,
  input  logic    wideMode,
  input  logic    byteSel,
  output logic    busy,
  output strobe_t strb
);

  localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_CYCLES - 1);

  logic             startCond;
  logic             condPrev;
  logic             selPrev;
  logic             busyReg;
  logic [CNT_W-1:0] cnt;
  logic             lastCycle;
  logic             readOk;

  assign startCond = chipEn & ~chipSelN & ~readConvN;
  assign lastCycle = busyReg && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busyReg  <= 1'b0;
      cnt      <= '0;
      condPrev <= 1'b0;
      selPrev  <= 1'b0;
    end else begin
      condPrev <= startCond;
      selPrev  <= byteSel;
      if (!busyReg) begin
        if (startCond && !condPrev) begin
          busyReg <= 1'b1;
          cnt     <= '0;
        end
      end else if (lastCycle) begin
        busyReg <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign busy   = busyReg;
  assign readOk = chipEn & ~chipSelN & readConvN & ~busyReg;

  always_comb begin
    strb            = '0;
    strb.loadResult = lastCycle;
    strb.readWide   = readOk & wideMode;
    strb.readHigh   = readOk & ~wideMode & ~byteSel & ~selPrev;
    strb.readLow    = readOk & ~wideMode &  byteSel &  selPrev;
  end

  // R2: busy rises only after a fresh start condition
  p_start_edge_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(startCond) && !$past(condPrev)));

  // R4: an ongoing conversion only advances, it is never restarted
  p_no_restart_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(busyReg) && busyReg) |-> (cnt == $past(cnt) + CNT_W'(1)));

  // R6: no read strobe while converting
  p_no_read_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busyReg |-> !(strb.readWide || strb.readHigh || strb.readLow));

  // R10: lower group never directly follows the upper group
  p_bbm_low_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(strb.readLow) |-> !$past(strb.readHigh));

  // R10: upper group never directly follows the lower group
  p_bbm_high_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(strb.readHigh) |-> !$past(strb.readLow));

endmodule

// File: rtl/result_path.sv
module result_path
  import adcbus_pkg::*;
#(
  parameter int RESULT_W = 12,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strb,
  input  logic [RESULT_W-1:0] sampleIn,
  output logic [RESULT_W-1:0] dataOut,
  output logic [RESULT_W-1:0] dataOe
);

  localparam int LOW_BITS = RESULT_W - BYTE_W;
  localparam int HI_BASE  = RESULT_W - BYTE_W;

  logic [RESULT_W-1:0] resultReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      resultReg <= '0;
    end else if (strb.loadResult) begin
      resultReg <= sampleIn;
    end
  end

  for (genvar i = 0; i < RESULT_W; i++) begin : g_line
    localparam logic IS_HI   = (i >= HI_BASE);
    localparam logic IS_LO   = (i < BYTE_W);
    localparam logic IS_KEEP = (i < LOW_BITS);
    logic passBit;
    assign passBit    = strb.readWide | (IS_HI & strb.readHigh) | (IS_KEEP & strb.readLow);
    assign dataOe[i]  = strb.readWide | (IS_HI & strb.readHigh) | (IS_LO & strb.readLow);
    assign dataOut[i] = passBit ? resultReg[i] : 1'b0;
  end

  // R5: result register holds the sample present at the loading edge
  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    $past(strb.loadResult) |-> (resultReg == $past(sampleIn)));

  // R10: the two byte strobes never coincide
  p_groups_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(strb.readHigh && strb.readLow));

  // R11: a disabled line carries zero
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    ((dataOut & ~dataOe) == '0));

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adcbus_pkg::*;
#(
  parameter int CONV_CYCLES = 13,
  parameter int RESULT_W    = 12,
  parameter int BYTE_W      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                chipEn,
  input  logic                chipSelN,
  input  logic                readConvN,
  input  logic                wideMode,
  input  logic                byteSel,
  input  logic [RESULT_W-1:0] sampleIn,
  output logic                busy,
  output logic [RESULT_W-1:0] dataOut,
  output logic [RESULT_W-1:0] dataOe
);

  strobe_t strb;

  conv_ctrl #(
    .CONV_CYCLES(CONV_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .chipEn   (chipEn),
    .chipSelN (chipSelN),
    .readConvN(readConvN),
    .wideMode (wideMode),
    .byteSel  (byteSel),
    .busy     (busy),
    .strb     (strb)
  );

  result_path #(
    .RESULT_W(RESULT_W),
    .BYTE_W  (BYTE_W)
  ) u_path (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .sampleIn(sampleIn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

endmodule

// File: tb/adc_bus_ctrl_tb.sv
module adc_bus_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CONV_LEN   = 13;

  logic        clk = 1'b0;
  logic        rst;
  logic        chipEn, chipSelN, readConvN, wideMode, byteSel;
  logic [11:0] sampleIn;
  logic        busy;
  logic [11:0] dataOut, dataOe;

  int checks = 0;
  int errors = 0;
  logic [11:0] curResult;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_ctrl u_dut (
    .clk(clk), .rst(rst), .chipEn(chipEn), .chipSelN(chipSelN),
    .readConvN(readConvN), .wideMode(wideMode), .byteSel(byteSel),
    .sampleIn(sampleIn), .busy(busy), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // expected read outputs with busy low and byteSel steady
  function automatic logic [23:0] expRead(input logic ce, input logic csn, input logic rcn,
                                          input logic wide, input logic sel, input logic [11:0] res);
    logic [11:0] oe, dv;
    oe = 12'h000;
    dv = 12'h000;
    if (ce && !csn && rcn) begin
      if (wide)      begin oe = 12'hFFF; dv = res; end
      else if (!sel) begin oe = 12'hFF0; dv = res & 12'hFF0; end
      else           begin oe = 12'h0FF; dv = res & 12'h00F; end
    end
    return {oe, dv};
  endfunction

  task automatic setCtl(input logic ce, input logic csn, input logic rcn);
    chipEn = ce; chipSelN = csn; readConvN = rcn;
  endtask

  // run one conversion with the given input arriving last (0 ce, 1 cs, 2 rc)
  task automatic convert(input int lastSig, input logic [11:0] smp);
    int n;
    @(negedge clk);
    case (lastSig)
      0: setCtl(1'b0, 1'b0, 1'b0);
      1: setCtl(1'b1, 1'b1, 1'b0);
      default: setCtl(1'b1, 1'b0, 1'b1);
    endcase
    sampleIn = smp;
    @(negedge clk);
    @(negedge clk);
    setCtl(1'b1, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk("R2 busy after start", busy, 1'b1);
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); #1; end
    chk("R3 busy length", n, CONV_LEN);
    curResult = smp;
    setCtl(1'b1, 1'b0, 1'b1);
  endtask

  task automatic readAll(input logic [11:0] res);
    logic [23:0] e;
    wideMode = 1'b1; setCtl(1'b1, 1'b0, 1'b1);
    @(negedge clk); #1;
    e = expRead(1, 0, 1, 1, byteSel, res);
    chk("R5 R7 wide oe", dataOe, e[23:12]);
    chk("R5 R7 wide data", dataOut, e[11:0]);
    wideMode = 1'b0; byteSel = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    e = expRead(1, 0, 1, 0, 0, res);
    chk("R8 upper oe", dataOe, e[23:12]);
    chk("R8 upper data", dataOut, e[11:0]);
    byteSel = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    e = expRead(1, 0, 1, 0, 1, res);
    chk("R9 lower oe", dataOe, e[23:12]);
    chk("R9 lower data", dataOut, e[11:0]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [23:0] e;
    int n;
    rst = 1'b1; setCtl(1'b0, 1'b1, 1'b1);
    wideMode = 1'b1; byteSel = 1'b0; sampleIn = 12'h000;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 oe after reset", dataOe, 12'h000);
    setCtl(1'b1, 1'b0, 1'b1);
    @(negedge clk); #1;
    chk("R1 result cleared oe", dataOe, 12'hFFF);
    chk("R1 result cleared data", dataOut, 12'h000);

    // R2 each input arriving last, R5 R7 R8 R9 reads
    convert(0, 12'hA5C); readAll(12'hA5C);
    convert(1, 12'hFFF); readAll(12'hFFF);
    convert(2, 12'h3E1); readAll(12'h3E1);
    convert(2, 12'h000); readAll(12'h000);

    // R4 retrigger while busy, R5 late sample change, R6 no read while busy
    @(negedge clk);
    setCtl(1'b1, 1'b0, 1'b1); wideMode = 1'b1; sampleIn = 12'h123;
    @(negedge clk);
    setCtl(1'b1, 1'b0, 1'b0);
    @(negedge clk); #1;
    n = 0;
    while (busy && n < 50) begin
      n++;
      if (n == 4) begin
        readConvN = 1'b1; #1;
        chk("R6 no read while busy", dataOe, 12'h000);
      end
      if (n == 5) begin readConvN = 1'b0; sampleIn = 12'hBD7; end
      @(negedge clk); #1;
    end
    chk("R4 retrigger ignored length", n, CONV_LEN);
    repeat (3) begin
      @(negedge clk); #1;
      chk("R4 held condition no restart", busy, 1'b0);
    end
    readAll(12'hBD7);
    curResult = 12'hBD7;

    // R10 break-before-make on byteSel toggles
    wideMode = 1'b0; byteSel = 1'b0; setCtl(1'b1, 1'b0, 1'b1);
    @(negedge clk); @(negedge clk); #1;
    chk("R10 upper before toggle", dataOe, 12'hFF0);
    byteSel = 1'b1; #1;
    chk("R10 gap after rise", dataOe, 12'h000);
    chk("R11 gap data zero", dataOut, 12'h000);
    @(negedge clk); #1;
    chk("R10 lower after gap", dataOe, 12'h0FF);
    byteSel = 1'b0; #1;
    chk("R10 gap after fall", dataOe, 12'h000);
    @(negedge clk); #1;
    chk("R10 upper after gap", dataOe, 12'hFF0);
    wideMode = 1'b1; byteSel = 1'b1; #1;
    chk("R7 byteSel ignored wide", dataOe, 12'hFFF);
    chk("R7 byteSel ignored data", dataOut, 12'hBD7);

    // R6 R7 R8 R9 R11 sweep over all control combinations
    sampleIn = curResult;
    for (int k = 0; k < 32; k++) begin
      logic ce, csn, rcn, wd, sl;
      {wd, sl, ce, csn, rcn} = 5'(k);
      @(negedge clk);
      setCtl(1'b0, 1'b1, 1'b1); byteSel = sl;
      @(negedge clk); @(negedge clk);
      setCtl(ce, csn, rcn); wideMode = wd; #1;
      e = expRead(ce, csn, rcn, wd, sl, curResult);
      chk("R6 sweep oe", dataOe, e[23:12]);
      chk("R11 sweep data", dataOut, e[11:0]);
      n = 0;
      @(negedge clk); #1;
      while (busy && n < 50) begin n++; @(negedge clk); #1; end
    end

    // R1 reset in the middle of a conversion
    @(negedge clk);
    setCtl(1'b1, 1'b0, 1'b1); sampleIn = 12'h777;
    @(negedge clk); setCtl(1'b1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; setCtl(1'b0, 1'b1, 1'b1); #1;
    chk("R1 busy cleared mid conversion", busy, 1'b0);
    chk("R1 oe cleared mid conversion", dataOe, 12'h000);
    @(negedge clk); wideMode = 1'b1; setCtl(1'b1, 1'b0, 1'b1); #1;
    chk("R1 result zero after reset", dataOut, 12'h000);
    @(negedge clk); #1;
    chk("R1 no conversion after reset", busy, 1'b0);

    finishRun();
  end

endmodule